// File: doc/BRIEF.md
# Aliased Guest Address Region Checker

This block screens every guest memory access before it reaches the backing store. A guest issues a 64-bit effective address together with an access width and an access kind (data read, data write or instruction fetch). Only the low 32 address bits are decoded, so the whole 64-bit space folds onto a single 4 GiB region. The block reports the 32-bit physical byte offset inside that region and a fault flag with a two-bit cause.

The 4 GiB region has three parts. The lowest 4 MiB is an unmapped guard that catches null-pointer accesses. The span from 0x0040_0000 up to 0x1000_0000 holds read-only code. Everything from 0x1000_0000 to the top is read/write data. Instruction fetches are valid only inside the part of the code span that is actually loaded. Misaligned accesses are legal, so the block checks only which regions the first and last byte of the access fall in. An access that runs past the top of the region wraps to offset 0.

The decision logic is combinational. A parameter chooses whether the result goes through one output register (the default) or reaches the outputs in the same cycle.

Top module: `guest_region_check`

## Requirements
- R1: `out_phys` equals bits [31:0] of the effective address. Bits [63:32] have no effect on the offset or on the fault result.
- R2: An access with either end below 0x0040_0000 faults with cause 01 (null guard).
- R3: A write with either end in [0x0040_0000, 0x1000_0000) faults with cause 10. Reads of that span never fault.
- R4: Reads and writes with both ends at or above 0x1000_0000 never fault, whatever their alignment.
- R5: A fetch with either end at or above 0x1000_0000 faults with cause 11.
- R6: A fetch faults with cause 11 when either end lies at or beyond 0x0040_0000 + min(`code_len`, 0x0FC0_0000). The cap 0x0FC0_0000 is 252 MiB.
- R7: Both the first byte and the last byte are checked. The last byte is at (addr[31:0] + bytes − 1) mod 2^32, so an access past 0xFFFF_FFFF continues at offset 0.
- R8: When the two ends give different causes, the reported cause is 01 if either end gives 01, otherwise 10 if either end gives 10, otherwise 11.
- R9: `acc_size` encodes 00=1, 01=2, 10=4 and 11=8 bytes. `acc_kind` encodes 00 read, 01 write and 10 fetch. The reserved kind 11 faults with cause 11 outside the guard region.
- R10: With the output register enabled, `out_valid` and the results follow `in_valid` by exactly one cycle. Synchronous reset drives every output to zero.
- R11: `out_fault` is 1 exactly when `out_cause` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Access request present |
| eff_addr | input | 64 | Guest effective address |
| acc_size | input | 2 | Access width code |
| acc_kind | input | 2 | Access kind code |
| code_len | input | 32 | Loaded code size in bytes |
| out_valid | output | 1 | Result present |
| out_phys | output | 32 | Physical byte offset |
| out_fault | output | 1 | Access refused |
| out_cause | output | 2 | Fault cause |

## Verification
Each result is due exactly one clock edge after its request, because the output register is the only register in the path. The driver applies a request at a falling edge and queues the expected result. The monitor takes one queue entry per cycle, one time unit after the next rising edge, and compares it there. Idle cycles are queued as entries with `out_valid` low, so the monitor also detects a result that appears in the wrong cycle. Reset values are sampled while reset is held, before the first request.

// File: rtl/gr_pkg.sv
package gr_pkg;

    localparam int PHYS_W = 32;

    typedef enum logic [1:0] {
        CZ_NONE   = 2'b00,
        CZ_NULL   = 2'b01,
        CZ_CODEWR = 2'b10,
        CZ_RANGE  = 2'b11
    } cause_e;

    typedef enum logic [1:0] {
        AK_READ  = 2'b00,
        AK_WRITE = 2'b01,
        AK_FETCH = 2'b10,
        AK_RSVD  = 2'b11
    } kind_e;

    typedef struct packed {
        logic [PHYS_W-1:0] phys;
        logic              fault;
        cause_e            cause;
    } result_t;

    // byte count minus one for a size code
    function automatic logic [PHYS_W-1:0] span_m1(input logic [1:0] sz);
        logic [PHYS_W-1:0] r;
        r = (PHYS_W'(1) << sz) - PHYS_W'(1);
        return r;
    endfunction

    // cause for one byte offset
    function automatic cause_e classify(
        input logic [PHYS_W-1:0] off,
        input kind_e             kind,
        input logic [PHYS_W-1:0] code_base,
        input logic [PHYS_W-1:0] data_base,
        input logic [PHYS_W-1:0] fetch_end
    );
        cause_e c;
        if (off < code_base) begin
            c = CZ_NULL;
        end else if (kind == AK_RSVD) begin
            c = CZ_RANGE;
        end else if (off < data_base) begin
            if (kind == AK_WRITE)
                c = CZ_CODEWR;
            else if (kind == AK_FETCH && off >= fetch_end)
                c = CZ_RANGE;
            else
                c = CZ_NONE;
        end else begin
            c = (kind == AK_FETCH) ? CZ_RANGE : CZ_NONE;
        end
        return c;
    endfunction

    // fixed priority: guard, then code write, then range
    function automatic cause_e pick(input cause_e a, input cause_e b);
        cause_e c;
        if (a == CZ_NULL || b == CZ_NULL)
            c = CZ_NULL;
        else if (a == CZ_CODEWR || b == CZ_CODEWR)
            c = CZ_CODEWR;
        else if (a == CZ_RANGE || b == CZ_RANGE)
            c = CZ_RANGE;
        else
            c = CZ_NONE;
        return c;
    endfunction

endpackage

// File: rtl/gr_fetch_limit.sv
module gr_fetch_limit
    import gr_pkg::*;
#(
    parameter logic [PHYS_W-1:0] CODE_BASE = 32'h0040_0000,
    parameter logic [PHYS_W-1:0] CODE_CAP  = 32'h0FC0_0000
) (
    input  logic [PHYS_W-1:0] code_len,
    output logic [PHYS_W-1:0] fetch_end
);
    logic [PHYS_W-1:0] eff_len;

    always_comb begin
        eff_len   = (code_len > CODE_CAP) ? CODE_CAP : code_len;
        fetch_end = CODE_BASE + eff_len;
    end
endmodule

// File: rtl/gr_endpoint.sv
module gr_endpoint
    import gr_pkg::*;
#(
    parameter logic [PHYS_W-1:0] CODE_BASE = 32'h0040_0000,
    parameter logic [PHYS_W-1:0] DATA_BASE = 32'h1000_0000
) (
    input  logic [PHYS_W-1:0] off,
    input  kind_e             kind,
    input  logic [PHYS_W-1:0] fetch_end,
    output cause_e            cause,
    output logic              bad
);
    always_comb begin
        cause = classify(off, kind, CODE_BASE, DATA_BASE, fetch_end);
        bad   = (cause != CZ_NONE);
    end
endmodule

// File: rtl/gr_merge.sv
module gr_merge
    import gr_pkg::*;
#(
    parameter int N_ENDS = 2
) (
    input  cause_e [N_ENDS-1:0] end_cause,
    input  logic   [N_ENDS-1:0] end_bad,
    output cause_e              cause,
    output logic                fault
);
    always_comb begin
        cause = CZ_NONE;
        for (int i = 0; i < N_ENDS; i++)
            cause = pick(cause, end_cause[i]);
        fault = |end_bad;
    end
endmodule

// File: rtl/gr_outstage.sv
module gr_outstage
    import gr_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    v_in,
    input  result_t r_in,
    output logic    v_out,
    output result_t r_out
);
    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    v_out <= 1'b0;
                    r_out <= '0;
                end else begin
                    v_out <= v_in;
                    r_out <= r_in;
                end
            end
        end else begin : g_pass
            always_comb begin
                v_out = v_in;
                r_out = r_in;
            end
        end
    endgenerate
endmodule

// File: rtl/guest_region_check.sv
module guest_region_check
    import gr_pkg::*;
#(
    parameter logic [31:0] CODE_BASE = 32'h0040_0000,
    parameter logic [31:0] DATA_BASE = 32'h1000_0000,
    parameter logic [31:0] CODE_CAP  = 32'h0FC0_0000,
    parameter bit          REG_OUT   = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [63:0] eff_addr,
    input  logic [1:0]  acc_size,
    input  logic [1:0]  acc_kind,
    input  logic [31:0] code_len,
    output logic        out_valid,
    output logic [31:0] out_phys,
    output logic        out_fault,
    output logic [1:0]  out_cause
);
    localparam int N_ENDS = 2;

    logic [PHYS_W-1:0]          lo_off;
    logic [PHYS_W-1:0]          fetch_end;
    logic [N_ENDS-1:0][PHYS_W-1:0] ends;
    cause_e [N_ENDS-1:0]        end_cause;
    logic   [N_ENDS-1:0]        end_bad;
    cause_e                     comb_cause;
    logic                       comb_fault;
    kind_e                      kind;
    result_t                    comb_res;
    result_t                    reg_res;

    always_comb begin
        lo_off  = eff_addr[PHYS_W-1:0];
        kind    = kind_e'(acc_kind);
        ends[0] = lo_off;
        ends[1] = lo_off + span_m1(acc_size);
    end

    gr_fetch_limit #(.CODE_BASE(CODE_BASE), .CODE_CAP(CODE_CAP)) u_lim (
        .code_len (code_len),
        .fetch_end(fetch_end)
    );

    generate
        for (genvar g = 0; g < N_ENDS; g++) begin : g_end
            gr_endpoint #(.CODE_BASE(CODE_BASE), .DATA_BASE(DATA_BASE)) u_ep (
                .off      (ends[g]),
                .kind     (kind),
                .fetch_end(fetch_end),
                .cause    (end_cause[g]),
                .bad      (end_bad[g])
            );
        end
    endgenerate

    gr_merge #(.N_ENDS(N_ENDS)) u_merge (
        .end_cause(end_cause),
        .end_bad  (end_bad),
        .cause    (comb_cause),
        .fault    (comb_fault)
    );

    always_comb begin
        comb_res.phys  = lo_off;
        comb_res.fault = comb_fault;
        comb_res.cause = comb_cause;
    end

    gr_outstage #(.REG_OUT(REG_OUT)) u_out (
        .clk  (clk),
        .rst  (rst),
        .v_in (in_valid),
        .r_in (comb_res),
        .v_out(out_valid),
        .r_out(reg_res)
    );

    always_comb begin
        out_phys  = reg_res.phys;
        out_fault = reg_res.fault;
        out_cause = reg_res.cause;
    end

    // ---------------- assertions ----------------
    p_null_guard_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && lo_off < CODE_BASE) |-> (comb_fault && comb_cause == CZ_NULL));

    p_code_write_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && acc_kind == AK_WRITE && lo_off >= CODE_BASE && lo_off < DATA_BASE)
        |-> (comb_fault && comb_cause == CZ_CODEWR));

    p_data_rw_ok_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && acc_kind[1] == 1'b0 && lo_off >= DATA_BASE && lo_off <= 32'hFFFF_FFF8)
        |-> !comb_fault);

    p_fetch_data_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && acc_kind == AK_FETCH && lo_off >= DATA_BASE && lo_off <= 32'hFFFF_FFF8)
        |-> (comb_fault && comb_cause == CZ_RANGE));

    p_fault_iff_cause_r11: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_fault == (out_cause != 2'b00)));

    generate
        if (REG_OUT) begin : g_chk
            p_alias_phys_r1: assert property (@(posedge clk) disable iff (rst)
                (in_valid && !rst) |=> (out_valid && out_phys == $past(eff_addr[31:0])));
            p_idle_r10: assert property (@(posedge clk) disable iff (rst)
                (!in_valid && !rst) |=> !out_valid);
        end
    endgenerate

endmodule

// File: tb/tb_guest_region_check.sv
module tb_guest_region_check;

    typedef struct {
        bit        v;
        bit [31:0] phys;
        bit        fault;
        bit [1:0]  cause;
        string     req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] eff_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [1:0]  acc_kind = '0;
    logic [31:0] code_len = 32'h0000_1000;
    logic        out_valid;
    logic [31:0] out_phys;
    logic        out_fault;
    logic [1:0]  out_cause;

    int checks = 0;
    int errors = 0;
    exp_t q[$];
    bit done = 1'b0;

    always #5 clk = ~clk;

    guest_region_check dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .eff_addr(eff_addr),
        .acc_size(acc_size), .acc_kind(acc_kind), .code_len(code_len),
        .out_valid(out_valid), .out_phys(out_phys), .out_fault(out_fault),
        .out_cause(out_cause)
    );

    // reference model written from the requirements
    function automatic bit [1:0] m_at(bit [31:0] off, bit [1:0] k, bit [31:0] clen);
        bit [31:0] lim;
        lim = (clen > 32'h0FC0_0000) ? 32'h0FC0_0000 : clen;
        if (off < 32'h0040_0000) return 2'b01;
        if (k == 2'b11) return 2'b11;
        if (off < 32'h1000_0000) begin
            if (k == 2'b01) return 2'b10;
            if (k == 2'b10 && (off - 32'h0040_0000) >= lim) return 2'b11;
            return 2'b00;
        end
        if (k == 2'b10) return 2'b11;
        return 2'b00;
    endfunction

    function automatic bit [1:0] m_prio(bit [1:0] a, bit [1:0] b);
        if (a == 2'b01 || b == 2'b01) return 2'b01;
        if (a == 2'b10 || b == 2'b10) return 2'b10;
        if (a == 2'b11 || b == 2'b11) return 2'b11;
        return 2'b00;
    endfunction

    task automatic drive(bit [63:0] a, bit [1:0] sz, bit [1:0] k, string req);
        exp_t e;
        bit [31:0] first;
        bit [31:0] last;
        int nb;
        @(negedge clk);
        in_valid = 1'b1; eff_addr = a; acc_size = sz; acc_kind = k;
        nb    = 1 << sz;
        first = a[31:0];
        last  = first + 32'(nb - 1);
        e.v     = 1'b1;
        e.phys  = first;
        e.cause = m_prio(m_at(first, k, code_len), m_at(last, k, code_len));
        e.fault = (e.cause != 2'b00);
        e.req   = req;
        q.push_back(e);
    endtask

    task automatic idle(string req);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b0; eff_addr = 64'hFFFF_FFFF_FFFF_FFFF;
        e.v = 1'b0; e.phys = '0; e.fault = 1'b0; e.cause = '0; e.req = req;
        q.push_back(e);
    endtask

    // monitor: results are due one edge after the request
    always @(posedge clk) begin
        #1;
        if (!rst && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (out_valid !== e.v ||
                (e.v && (out_phys !== e.phys || out_fault !== e.fault || out_cause !== e.cause))) begin
                errors++;
                $display("FAIL %s: got v=%0b phys=%h fault=%0b cause=%0b exp v=%0b phys=%h fault=%0b cause=%0b",
                         e.req, out_valid, out_phys, out_fault, out_cause,
                         e.v, e.phys, e.fault, e.cause);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_phys !== 32'h0 || out_fault !== 1'b0 || out_cause !== 2'b00) begin
            errors++;
            $display("FAIL R10 reset: got v=%0b phys=%h fault=%0b cause=%0b exp all zero",
                     out_valid, out_phys, out_fault, out_cause);
        end
        rst = 1'b0;

        // R1 upper bits ignored
        drive(64'hDEAD_BEEF_1000_0000, 2'b11, 2'b00, "R1 alias read");
        drive(64'h0000_0001_0000_1000, 2'b00, 2'b00, "R1 R2 alias into guard");
        // R2 guard
        drive(64'h0000_0000_0000_1000, 2'b10, 2'b01, "R2 guard write");
        drive(64'h0000_0000_0000_0000, 2'b01, 2'b10, "R2 R8 guard fetch");
        // R3 code
        drive(64'h0000_0000_0040_0000, 2'b10, 2'b01, "R3 code write");
        drive(64'h7000_0000_0040_0010, 2'b11, 2'b00, "R3 code read");
        // R4 data misaligned
        drive(64'h0000_0000_1000_0003, 2'b11, 2'b01, "R4 misaligned write");
        drive(64'h0000_0000_FFFF_FFFC, 2'b10, 2'b01, "R4 top write");
        // R5 fetch from data
        drive(64'h0000_0000_2000_0000, 2'b10, 2'b10, "R5 fetch data");
        // R6 fetch limit with code_len 0x1000
        drive(64'h0000_0000_0040_0FFC, 2'b10, 2'b10, "R6 fetch inside");
        drive(64'h0000_0000_0040_0FFE, 2'b10, 2'b10, "R6 R7 fetch past end");
        drive(64'h0000_0000_0040_2000, 2'b10, 2'b00, "R6 read past loaded ok");
        // R7 straddle and wrap
        drive(64'h0000_0000_0FFF_FFFE, 2'b10, 2'b01, "R7 write code to data");
        drive(64'h0000_0000_003F_FFFE, 2'b10, 2'b00, "R7 read guard to code");
        drive(64'h0000_0003_FFFF_FFFE, 2'b10, 2'b00, "R7 wrap to zero");
        drive(64'h0000_0000_003F_FFFF, 2'b01, 2'b01, "R8 guard over code write");
        // R9 size and kind codes
        drive(64'h0000_0000_0FFF_FFFF, 2'b00, 2'b00, "R9 one byte code read");
        drive(64'h0000_0000_0FFF_FFFF, 2'b01, 2'b01, "R9 R8 two byte write straddle");
        drive(64'h0000_0000_3000_0000, 2'b00, 2'b11, "R9 reserved kind");
        // R10 idle cycle
        idle("R10 idle");
        drive(64'h0000_0000_1234_5678, 2'b01, 2'b00, "R10 after idle");
        // R6 cap: huge code_len
        @(negedge clk);
        in_valid = 1'b0;
        code_len = 32'hFFFF_FFFF;
        begin
            exp_t e;
            e.v = 1'b0; e.phys = '0; e.fault = 1'b0; e.cause = '0; e.req = "R10 idle";
            q.push_back(e);
        end
        drive(64'h0000_0000_0FFF_FFFC, 2'b10, 2'b10, "R6 fetch at cap");
        drive(64'h0000_0000_0FFF_FFFE, 2'b10, 2'b10, "R6 R5 fetch over cap");
        code_len = 32'h0000_0000;
        drive(64'h0000_0000_0040_0000, 2'b00, 2'b10, "R6 empty code");
        drive(64'h0000_0000_0040_0000, 2'b00, 2'b00, "R11 no fault");
        idle("R10 final idle");
        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: got timeout exp completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule